// File: doc/BRIEF.md
# Auxiliary Counter Access Permission Checker

This block decides, for one read or write request to an auxiliary event counter, which single outcome the request gets: it proceeds, it reads as zero, it is undefined, or it is redirected to privilege level 1, 2 or 3. The requester presents its privilege level, the two instruction fields that together name the counter, a read/write flag and a snapshot of the control bits that gate counter access. The block tests the possible outcomes in a fixed order and returns the first that applies.

The decision logic is combinational. The outcome is captured in a register on the cycle a request strobe is seen and is presented, with a valid flag, on the following cycle. Several bits depend on the counter index. The counters from a parameterised split point upward share one group trap bit. Each counter also has its own bit in a wide fine-grained trap vector, and that bit's position is computed from the index. Which counters exist is set by two parameters: a count and an implementation mask. Raising an exception is not part of this block. It only produces the outcome code.

Top module: `ctr_perm_check`

## Requirements
- R1: The counter index is `{crm_lsb, opc1}`, with crm_lsb as bit 3. If the index is at or above NUM_CTRS, or its bit in IMPL_MASK is clear, the outcome is UNDEF for reads and writes at every level, and this check comes before every other one.
- R2: A request sampled with req_valid high raises out_valid, with its code, on the next cycle. A cycle without req_valid gives out_valid low on the next cycle, and out_code keeps its last value. Reset clears out_valid and sets out_code to 0.
- R3: A read at level 0 with user_en low traps to level 2 if host_tge is high, and to level 1 if host_tge is low.
- R4: At levels 0 and 1, a request whose index is at or above GROUP_SPLIT (default 8) traps to level 2 when hyp_group_trap is high. This applies to reads (after the R3 check) and to writes (before the level check of R9).
- R5: A read at level 0 or 1 that passes R3 and R4 traps to level 2 when hyp_ctr_trap is high. At level 2, hyp_ctr_trap has no effect.
- R6: A read at level 0 that passes R3 to R5 traps to level 2 when fgt_en is high and bit FG_BASE+2*index (default FG_BASE=18) of fgt_vec is high. When host_mode is high the check is skipped. At levels 1 and 2, fgt_vec has no effect.
- R7: A read at levels 0 to 2 that passes all earlier checks traps to level 3 when mon_ctr_trap is high.
- R8: A read at levels 0 to 2 with a valid index and with both mon_undef_prio and mon_ctr_trap high is UNDEF, whatever the other control bits are.
- R9: A write at level 3 is ALLOW. A write at any other level that passes R1 and R4 is UNDEF, and user_en, hyp_ctr_trap, the fine-grained vector and the monitor bits have no effect on writes.
- R10: A read at levels 0 to 2 that no trap catches is RDZERO if rd_zero is high and ALLOW otherwise. A read at level 3 with a valid index is always ALLOW.
- R11: The 3-bit outcome codes are: ALLOW=0, RDZERO=1, UNDEF=2, TRAP_L1=3, TRAP_L2=4, TRAP_L3=5. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_level | input | 2 | Privilege level of the requester, 0 to 3 |
| req_write | input | 1 | 1 = write, 0 = read |
| crm_lsb | input | 1 | Low bit of the CRm field, index bit 3 |
| opc1 | input | 3 | opc1 field, index bits 2:0 |
| user_en | input | 1 | User-level access enable |
| host_tge | input | 1 | Routes user-enable traps to level 2 |
| hyp_group_trap | input | 1 | Level-2 trap for the upper counter group |
| hyp_ctr_trap | input | 1 | Level-2 counter trap |
| mon_ctr_trap | input | 1 | Level-3 counter trap |
| mon_undef_prio | input | 1 | Turns the level-3 trap into an early UNDEF |
| fgt_en | input | 1 | Fine-grained trap enable |
| fgt_vec | input | FG_W | Fine-grained trap vector |
| rd_zero | input | 1 | Reads below level 3 return zero |
| host_mode | input | 1 | Host mode, skips the fine-grained check |
| out_valid | output | 1 | Outcome valid |
| out_code | output | 3 | Outcome code (R11) |

## Verification
On every cycle the assertions check that the valid flag follows the strobe, that the code holds when there is no request, and that only legal codes appear. They also check the outcomes a rule fixes on its own, with no need for the full order: a bad index gives UNDEF, a valid level-3 read gives ALLOW, a write below level 3 never gives ALLOW, RDZERO never answers a write or a level-3 read, and the early-UNDEF case of R8. How the traps rank against each other shows up only in the bench's scenarios. Those scenarios set several conditions at once and check which one wins: user enable against host routing, the group split at index 8, the fine-grained bit position and its host-mode bypass, and the unimplemented hole inside the index range.

// File: rtl/ctr_perm_pkg.sv
package ctr_perm_pkg;

    localparam int          LVL_W   = 2;
    localparam int          IDX_W   = 4;
    localparam logic [1:0]  TOP_LVL = 2'd3;

    typedef enum logic [2:0] {
        OUT_ALLOW   = 3'd0,
        OUT_RDZERO  = 3'd1,
        OUT_UNDEF   = 3'd2,
        OUT_TRAP_L1 = 3'd3,
        OUT_TRAP_L2 = 3'd4,
        OUT_TRAP_L3 = 3'd5
    } perm_out_e;

    typedef struct packed {
        logic user_en;
        logic host_tge;
        logic hyp_group_trap;
        logic hyp_ctr_trap;
        logic mon_ctr_trap;
        logic mon_undef_prio;
        logic fgt_en;
        logic rd_zero;
        logic host_mode;
    } perm_ctl_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             wr;
    } perm_req_t;

    function automatic logic [IDX_W-1:0] join_index(input logic crm_bit,
                                                    input logic [2:0] opc);
        return {crm_bit, opc};
    endfunction

endpackage

// File: rtl/ctr_perm_index.sv
module ctr_perm_index
    import ctr_perm_pkg::*;
#(
    parameter int                    NUM_CTRS  = 16,
    parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = '1
) (
    input  logic             crm_lsb,
    input  logic [2:0]       opc1,
    output logic [IDX_W-1:0] idx,
    output logic             idx_bad
);
    always_comb begin
        idx     = join_index(crm_lsb, opc1);
        idx_bad = (int'(idx) >= NUM_CTRS) || !IMPL_MASK[idx];
    end
endmodule

// File: rtl/ctr_perm_fgsel.sv
module ctr_perm_fgsel
    import ctr_perm_pkg::*;
#(
    parameter int FG_W    = 64,
    parameter int FG_BASE = 18
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [FG_W-1:0]  fg_vec,
    output logic             fg_bit
);
    localparam int SEL_W = $clog2(FG_W);

    int pos;

    always_comb begin
        pos    = FG_BASE + 2 * int'(idx);
        fg_bit = 1'b0;
        if (pos < FG_W) begin
            fg_bit = fg_vec[pos[SEL_W-1:0]];
        end
    end
endmodule

// File: rtl/ctr_perm_decide.sv
module ctr_perm_decide
    import ctr_perm_pkg::*;
#(
    parameter int GROUP_SPLIT = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             idx_bad,
    input  perm_req_t        req,
    input  perm_ctl_t        ctl,
    input  logic             fg_bit,
    output perm_out_e        code
);
    logic low_lvl;
    logic at_top;
    logic grp_hit;

    always_comb begin
        low_lvl = (req.level <= 2'd1);
        at_top  = (req.level == TOP_LVL);
        grp_hit = low_lvl && (int'(idx) >= GROUP_SPLIT) && ctl.hyp_group_trap;

        if (idx_bad) begin
            code = OUT_UNDEF;
        end else if (req.wr) begin
            if (grp_hit)      code = OUT_TRAP_L2;
            else if (!at_top) code = OUT_UNDEF;
            else              code = OUT_ALLOW;
        end else if (at_top) begin
            code = OUT_ALLOW;
        end else if (ctl.mon_undef_prio && ctl.mon_ctr_trap) begin
            code = OUT_UNDEF;
        end else if (req.level == 2'd0 && !ctl.user_en) begin
            code = ctl.host_tge ? OUT_TRAP_L2 : OUT_TRAP_L1;
        end else if (grp_hit) begin
            code = OUT_TRAP_L2;
        end else if (low_lvl && ctl.hyp_ctr_trap) begin
            code = OUT_TRAP_L2;
        end else if (req.level == 2'd0 && ctl.fgt_en && !ctl.host_mode && fg_bit) begin
            code = OUT_TRAP_L2;
        end else if (ctl.mon_ctr_trap) begin
            code = OUT_TRAP_L3;
        end else if (ctl.rd_zero) begin
            code = OUT_RDZERO;
        end else begin
            code = OUT_ALLOW;
        end
    end
endmodule

// File: rtl/ctr_perm_check.sv
module ctr_perm_check
    import ctr_perm_pkg::*;
#(
    parameter int                    NUM_CTRS    = 16,
    parameter logic [(1<<IDX_W)-1:0] IMPL_MASK   = '1,
    parameter int                    GROUP_SPLIT = 8,
    parameter int                    FG_W        = 64,
    parameter int                    FG_BASE     = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_level,
    input  logic            req_write,
    input  logic            crm_lsb,
    input  logic [2:0]      opc1,
    input  logic            user_en,
    input  logic            host_tge,
    input  logic            hyp_group_trap,
    input  logic            hyp_ctr_trap,
    input  logic            mon_ctr_trap,
    input  logic            mon_undef_prio,
    input  logic            fgt_en,
    input  logic [FG_W-1:0] fgt_vec,
    input  logic            rd_zero,
    input  logic            host_mode,
    output logic            out_valid,
    output logic [2:0]      out_code
);
    logic [IDX_W-1:0] idx;
    logic             idx_bad;
    logic             fg_bit;
    perm_req_t        req;
    perm_ctl_t        ctl;
    perm_out_e        code_d;
    perm_out_e        code_q;

    always_comb begin
        req.level          = req_level;
        req.wr             = req_write;
        ctl.user_en        = user_en;
        ctl.host_tge       = host_tge;
        ctl.hyp_group_trap = hyp_group_trap;
        ctl.hyp_ctr_trap   = hyp_ctr_trap;
        ctl.mon_ctr_trap   = mon_ctr_trap;
        ctl.mon_undef_prio = mon_undef_prio;
        ctl.fgt_en         = fgt_en;
        ctl.rd_zero        = rd_zero;
        ctl.host_mode      = host_mode;
    end

    ctr_perm_index #(.NUM_CTRS(NUM_CTRS), .IMPL_MASK(IMPL_MASK)) index_i (
        .crm_lsb (crm_lsb),
        .opc1    (opc1),
        .idx     (idx),
        .idx_bad (idx_bad)
    );

    ctr_perm_fgsel #(.FG_W(FG_W), .FG_BASE(FG_BASE)) fgsel_i (
        .idx    (idx),
        .fg_vec (fgt_vec),
        .fg_bit (fg_bit)
    );

    ctr_perm_decide #(.GROUP_SPLIT(GROUP_SPLIT)) decide_i (
        .idx     (idx),
        .idx_bad (idx_bad),
        .req     (req),
        .ctl     (ctl),
        .fg_bit  (fg_bit),
        .code    (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            code_q    <= OUT_ALLOW;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                code_q <= code_d;
            end
        end
    end

    assign out_code = code_q;
endmodule

// File: rtl/ctr_perm_check_sva.sv
module ctr_perm_check_sva #(
    parameter int         NUM_CTRS    = 16,
    parameter logic [15:0] IMPL_MASK  = '1,
    parameter int         GROUP_SPLIT = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_level,
    input logic       req_write,
    input logic       crm_lsb,
    input logic [2:0] opc1,
    input logic       mon_ctr_trap,
    input logic       mon_undef_prio,
    input logic       out_valid,
    input logic [2:0] out_code
);
    logic [3:0] chk_idx;
    logic       chk_bad;

    always_comb begin
        chk_idx = {crm_lsb, opc1};
        chk_bad = (int'(chk_idx) >= NUM_CTRS) || !IMPL_MASK[chk_idx];
    end

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_code));

    assert_code_legal_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code <= 3'd5));

    assert_bad_index_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && chk_bad) |=> (out_code == 3'd2));

    assert_top_read_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !chk_bad && !req_write && req_level == 2'd3) |=> (out_code == 3'd0));

    assert_low_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_level != 2'd3) |=> (out_code == 3'd2 || out_code == 3'd4));

    assert_rdzero_scope_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_write || req_level == 2'd3)) |=> (out_code != 3'd1));

    assert_undef_prio_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !chk_bad && !req_write && req_level != 2'd3
         && mon_undef_prio && mon_ctr_trap) |=> (out_code == 3'd2));
endmodule

bind ctr_perm_check ctr_perm_check_sva #(
    .NUM_CTRS    (NUM_CTRS),
    .IMPL_MASK   (IMPL_MASK),
    .GROUP_SPLIT (GROUP_SPLIT)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_level      (req_level),
    .req_write      (req_write),
    .crm_lsb        (crm_lsb),
    .opc1           (opc1),
    .mon_ctr_trap   (mon_ctr_trap),
    .mon_undef_prio (mon_undef_prio),
    .out_valid      (out_valid),
    .out_code       (out_code)
);

// File: tb/ctr_perm_check_tb_top.sv
`timescale 1ns/1ps
module ctr_perm_check_tb_top;
    localparam int          T_NUM   = 12;
    localparam logic [15:0] T_MASK  = 16'h0FDF;
    localparam int          T_FGW   = 64;
    localparam int          T_FGB   = 18;

    localparam logic [2:0] C_ALLOW = 3'd0, C_RDZ = 3'd1, C_UNDEF = 3'd2,
                           C_T1 = 3'd3, C_T2 = 3'd4, C_T3 = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_level = '0;
    logic req_write = 1'b0;
    logic crm_lsb = 1'b0;
    logic [2:0] opc1 = '0;
    logic user_en = 1'b1, host_tge = 1'b0, hyp_group_trap = 1'b0, hyp_ctr_trap = 1'b0;
    logic mon_ctr_trap = 1'b0, mon_undef_prio = 1'b0, fgt_en = 1'b0, rd_zero = 1'b0, host_mode = 1'b0;
    logic [T_FGW-1:0] fgt_vec = '0;
    logic out_valid;
    logic [2:0] out_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [2:0] last_exp = C_ALLOW;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    ctr_perm_check #(.NUM_CTRS(T_NUM), .IMPL_MASK(T_MASK), .GROUP_SPLIT(8),
                     .FG_W(T_FGW), .FG_BASE(T_FGB)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_write(req_write), .crm_lsb(crm_lsb), .opc1(opc1), .user_en(user_en),
        .host_tge(host_tge), .hyp_group_trap(hyp_group_trap), .hyp_ctr_trap(hyp_ctr_trap),
        .mon_ctr_trap(mon_ctr_trap), .mon_undef_prio(mon_undef_prio), .fgt_en(fgt_en),
        .fgt_vec(fgt_vec), .rd_zero(rd_zero), .host_mode(host_mode),
        .out_valid(out_valid), .out_code(out_code)
    );

    // Spec model, written per level from the requirement list.
    function automatic logic [2:0] model();
        int k;
        k = {crm_lsb, opc1};
        if (k >= T_NUM || !T_MASK[k]) return C_UNDEF;                       // R1
        if (req_write) begin                                                  // R9
            if (req_level != 2'd3 && req_level != 2'd2 && k >= 8 && hyp_group_trap) return C_T2;
            return (req_level == 2'd3) ? C_ALLOW : C_UNDEF;
        end
        case (req_level)
            2'd3: return C_ALLOW;                                             // R10
            2'd2: begin
                if (mon_ctr_trap) return mon_undef_prio ? C_UNDEF : C_T3;
                return rd_zero ? C_RDZ : C_ALLOW;
            end
            2'd1: begin
                if (mon_ctr_trap && mon_undef_prio) return C_UNDEF;
                if (k >= 8 && hyp_group_trap) return C_T2;
                if (hyp_ctr_trap) return C_T2;
                if (mon_ctr_trap) return C_T3;
                return rd_zero ? C_RDZ : C_ALLOW;
            end
            default: begin
                if (mon_ctr_trap && mon_undef_prio) return C_UNDEF;
                if (!user_en) return host_tge ? C_T2 : C_T1;
                if (k >= 8 && hyp_group_trap) return C_T2;
                if (hyp_ctr_trap) return C_T2;
                if (fgt_en && !host_mode && fgt_vec[T_FGB + 2*k]) return C_T2;
                if (mon_ctr_trap) return C_T3;
                return rd_zero ? C_RDZ : C_ALLOW;
            end
        endcase
    endfunction

    task automatic clear_ctl();
        user_en = 1'b1; host_tge = 1'b0; hyp_group_trap = 1'b0; hyp_ctr_trap = 1'b0;
        mon_ctr_trap = 1'b0; mon_undef_prio = 1'b0; fgt_en = 1'b0; rd_zero = 1'b0;
        host_mode = 1'b0; fgt_vec = '0; req_write = 1'b0;
    endtask

    task automatic set_req(input logic [1:0] lvl, input int k, input logic wr);
        req_level = lvl;
        {crm_lsb, opc1} = 4'(k);
        req_write = wr;
    endtask

    // Driver: called at a falling edge with inputs already set.
    task automatic apply(input string tag, input logic [2:0] want);
        exp_q.push_back(want);
        tag_q.push_back(tag);
        last_exp = want;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic apply_model(input string tag);
        apply(tag, model());
    endtask

    // Monitor: compares each result against the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            logic [2:0] e;
            string t;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected out_valid, actual code %0d expected none", out_code);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_code !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %0d expected %0d", t, out_code, e);
                end
            end
        end
    end

    task automatic idle_check(input string tag);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_code !== last_exp) begin
            n_bad++;
            $display("FAIL %s: actual valid %0b code %0d expected valid 0 code %0d",
                     tag, out_valid, out_code, last_exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_code !== C_ALLOW) begin
            n_bad++;
            $display("FAIL R2 reset: actual valid %0b code %0d expected valid 0 code 0",
                     out_valid, out_code);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: out of range, hole at 5, index built from crm bit above opc1
        clear_ctl(); set_req(2'd3, 12, 1'b0); apply("R1 idx12", C_UNDEF);
        set_req(2'd3, 5, 1'b0);  apply("R1 hole5", C_UNDEF);
        set_req(2'd3, 5, 1'b1);  apply("R1 hole5 wr", C_UNDEF);
        set_req(2'd0, 4, 1'b0); user_en = 1'b0; apply("R1 idx4 ok", C_T1);
        clear_ctl(); set_req(2'd3, 11, 1'b0); apply("R1 idx11 ok", C_ALLOW);
        idle_check("R2 hold");

        // R3
        clear_ctl(); set_req(2'd0, 2, 1'b0); user_en = 1'b0; apply("R3 trap1", C_T1);
        host_tge = 1'b1; apply("R3 trap2", C_T2);
        // R4
        clear_ctl(); set_req(2'd1, 9, 1'b0); hyp_group_trap = 1'b1; apply("R4 idx9", C_T2);
        set_req(2'd1, 7, 1'b0); apply("R4 idx7", C_ALLOW);
        set_req(2'd2, 9, 1'b0); apply("R4 lvl2", C_ALLOW);
        set_req(2'd1, 10, 1'b1); apply("R4 write", C_T2);
        // R5
        clear_ctl(); set_req(2'd1, 1, 1'b0); hyp_ctr_trap = 1'b1; mon_ctr_trap = 1'b1;
        apply("R5 before mon", C_T2);
        set_req(2'd2, 1, 1'b0); hyp_ctr_trap = 1'b1; mon_ctr_trap = 1'b0; apply("R5 lvl2", C_ALLOW);
        // R6: bit 18+2*4 = 26
        clear_ctl(); set_req(2'd0, 4, 1'b0); fgt_en = 1'b1; fgt_vec[26] = 1'b1;
        apply("R6 bit26", C_T2);
        host_mode = 1'b1; apply("R6 host skip", C_ALLOW);
        host_mode = 1'b0; fgt_vec = '0; fgt_vec[24] = 1'b1; apply("R6 other bit", C_ALLOW);
        fgt_vec[26] = 1'b1; fgt_en = 1'b0; apply("R6 disabled", C_ALLOW);
        fgt_en = 1'b1; set_req(2'd1, 4, 1'b0); apply("R6 lvl1", C_ALLOW);
        // R7
        clear_ctl(); set_req(2'd2, 3, 1'b0); mon_ctr_trap = 1'b1; rd_zero = 1'b1;
        apply("R7 trap3", C_T3);
        set_req(2'd0, 3, 1'b0); apply("R7 lvl0", C_T3);
        // R8
        clear_ctl(); set_req(2'd0, 9, 1'b0); user_en = 1'b0; hyp_group_trap = 1'b1;
        mon_ctr_trap = 1'b1; mon_undef_prio = 1'b1; apply("R8 early undef", C_UNDEF);
        mon_ctr_trap = 1'b0; apply("R8 needs trap bit", C_T1);
        // R9
        clear_ctl(); set_req(2'd3, 6, 1'b1); hyp_ctr_trap = 1'b1; mon_ctr_trap = 1'b1;
        apply("R9 top write", C_ALLOW);
        set_req(2'd1, 6, 1'b1); apply("R9 low write", C_UNDEF);
        clear_ctl(); set_req(2'd0, 2, 1'b1); user_en = 1'b0; apply("R9 user ignored", C_UNDEF);
        // R10
        clear_ctl(); set_req(2'd2, 0, 1'b0); rd_zero = 1'b1; apply("R10 rdzero", C_RDZ);
        set_req(2'd3, 0, 1'b0); apply("R10 top read", C_ALLOW);
        set_req(2'd1, 0, 1'b0); hyp_ctr_trap = 1'b1; apply("R10 trap wins", C_T2);
        idle_check("R2 hold after trap");

        // R11 and general mix: random requests against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            req_level = r[1:0]; req_write = r[2]; {crm_lsb, opc1} = r[6:3];
            user_en = r[7] | r[8]; host_tge = r[9]; hyp_group_trap = r[10];
            hyp_ctr_trap = r[11] & r[12]; mon_ctr_trap = r[13] & r[14];
            mon_undef_prio = r[15]; fgt_en = r[16]; rd_zero = r[17]; host_mode = r[18];
            fgt_vec = {$urandom, $urandom};
            apply_model("R11 random");
            if (r[19] && r[20]) idle_check("R2 random idle");
        end

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual %0d pending results expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule